// File: doc/BRIEF.md
# Audio-Video Frame Multiplexer

This block merges two compressed media streams into one byte-wide stream of multiplex frames. An audio encoder delivers a fixed-size chunk per audio frame and a video encoder delivers any number of bytes up to a configured limit. Both arrive on their own valid/ready byte inputs and land in ping-pong storage, so the encoders can keep writing one half while the other half is being sent.

A one-cycle `aud_done` pulse marks the end of an audio chunk and asks for a swap. A swap is also requested on its own when the video half reaches its limit, so video can never overflow. At a swap the filled halves are handed to a serialiser. It emits a five-byte header first: a 16-bit start marker, a composition index, and the 16-bit frame length. The audio section follows, then the video section. A swap that arrives while a frame is still leaving is held until that frame's last byte has been taken.

Back-pressure rules: an input byte is taken on a clock edge where its valid and ready are both high. A source must hold its byte until that edge. The output offers a byte while `out_valid` is high and keeps it unchanged until a cycle with `out_ready` high. `out_last` marks the final byte of each frame.

Top module: `avmux`

## Requirements
- R1: A frame is the 5-byte header, then the audio section if present, then the video section if present. `out_last` is high with the final byte and with no other byte.
- R2: The header bytes, in order, are: marker high byte, marker low byte (marker = parameter `SOF`), index byte, length high byte, length low byte. The length is 5 + audio bytes + video bytes, big-endian.
- R3: The index byte is 0 for audio only, 1 for video only, and 2 for audio followed by video.
- R4: An `aud_done` pulse while the output is idle swaps both halves. The frame carries `AUD_BYTES` audio bytes in written order, followed by every video byte written since the last swap (0 to `VID_MAX`-1 bytes). With zero video bytes the frame is audio only.
- R5: Once the video half holds `VID_MAX` bytes, `vid_ready` is low and a video-only frame is formed from the video half alone. Audio bytes already written stay in place and go out with the next audio frame.
- R6: A swap requested while a frame is being sent waits until that frame's last byte has been accepted. `out_valid` is low in the cycle after every last byte. From `aud_done` until its swap, `aud_ready` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: During and right after reset, `out_valid` is low and both `aud_ready` and `vid_ready` are high.
- R9: While a frame is being sent, both sources can keep writing complete chunks into the free halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| aud_valid | input | 1 | Audio byte offered |
| aud_data | input | 8 | Audio byte |
| aud_ready | output | 1 | Audio byte can be taken |
| vid_valid | input | 1 | Video byte offered |
| vid_data | input | 8 | Video byte |
| vid_ready | output | 1 | Video byte can be taken |
| aud_done | input | 1 | One-cycle pulse: audio chunk complete, request swap |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the current frame |

## Verification
The bench builds the block with `AUD_BYTES`=3 and `VID_MAX`=4. With these values it can sweep every video count that can accompany audio, from the audio-only frame to three video bytes. It can also fill the video half in four writes to force the full-buffer swap. The small sizes keep each frame short, so a slow output pattern makes a second swap request, with fully loaded halves, land in the middle of a frame. This exercises the deferred swap, the one-cycle gap between frames and the back-pressure hold.

// File: rtl/avmux_pkg.sv
package avmux_pkg;
  localparam int HDR_BYTES = 5;

  typedef enum logic [7:0] {
    IDX_AUD = 8'd0,
    IDX_VID = 8'd1,
    IDX_AV  = 8'd2
  } frame_idx_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_HDR,
    TX_AUD,
    TX_VID
  } tx_state_e;
endpackage

// File: rtl/avmux_bank.sv
module avmux_bank #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          hold,
  output logic          in_ready,
  input  logic          swap,
  output logic [CW-1:0] fill_cnt,
  output logic          fill_sel,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [2][DEPTH];
  logic       wr_en;

  assign in_ready = !hold && (fill_cnt != CW'(DEPTH));
  assign wr_en    = in_valid && in_ready;
  assign rd_data  = mem[rd_sel][rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      fill_sel <= 1'b0;
    end else if (swap) begin
      fill_cnt <= '0;
      fill_sel <= ~fill_sel;
    end else if (wr_en) begin
      fill_cnt <= fill_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[fill_sel][fill_cnt[AW-1:0]] <= in_data;
  end
endmodule

// File: rtl/avmux_tx.sv
module avmux_tx
  import avmux_pkg::*;
#(
  parameter int          AUD_BYTES = 4,
  parameter int          VID_MAX   = 8,
  parameter logic [15:0] SOF       = 16'hB5C3,
  localparam int AAW = $clog2(AUD_BYTES),
  localparam int VAW = $clog2(VID_MAX),
  localparam int VCW = $clog2(VID_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_aud,
  input  logic [VCW-1:0] start_vcnt,
  input  logic           start_abank,
  input  logic           start_vbank,
  output logic           busy,
  output logic           a_sel,
  output logic [AAW-1:0] a_addr,
  input  logic [7:0]     a_data,
  output logic           v_sel,
  output logic [VAW-1:0] v_addr,
  input  logic [7:0]     v_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic           out_last
);
  tx_state_e      st, nxt_after;
  logic [15:0]    pos;
  logic           has_aud;
  logic [VCW-1:0] vcnt;
  logic           abank, vbank;
  logic [15:0]    frame_sz;
  frame_idx_e     idx;
  logic           sec_end, fire;

  assign frame_sz  = 16'(HDR_BYTES) + (has_aud ? 16'(AUD_BYTES) : 16'd0) + 16'(vcnt);
  assign idx       = has_aud ? ((vcnt != '0) ? IDX_AV : IDX_AUD) : IDX_VID;
  assign out_valid = (st != TX_IDLE);
  assign busy      = out_valid;
  assign fire      = out_valid && out_ready;
  assign a_sel     = abank;
  assign v_sel     = vbank;
  assign a_addr    = pos[AAW-1:0];
  assign v_addr    = pos[VAW-1:0];

  always_comb begin
    sec_end  = 1'b0;
    out_data = 8'h00;
    case (st)
      TX_HDR: begin
        sec_end = (pos == 16'(HDR_BYTES - 1));
        case (pos[2:0])
          3'd0:    out_data = SOF[15:8];
          3'd1:    out_data = SOF[7:0];
          3'd2:    out_data = idx;
          3'd3:    out_data = frame_sz[15:8];
          default: out_data = frame_sz[7:0];
        endcase
      end
      TX_AUD: begin
        sec_end  = (pos == 16'(AUD_BYTES - 1));
        out_data = a_data;
      end
      TX_VID: begin
        sec_end  = (pos == 16'(vcnt) - 16'd1);
        out_data = v_data;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (st)
      TX_HDR:  nxt_after = has_aud ? TX_AUD : ((vcnt != '0) ? TX_VID : TX_IDLE);
      TX_AUD:  nxt_after = (vcnt != '0) ? TX_VID : TX_IDLE;
      default: nxt_after = TX_IDLE;
    endcase
  end

  assign out_last = out_valid && sec_end && (nxt_after == TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      pos     <= '0;
      has_aud <= 1'b0;
      vcnt    <= '0;
      abank   <= 1'b0;
      vbank   <= 1'b0;
    end else if (st == TX_IDLE) begin
      if (start) begin
        st      <= TX_HDR;
        pos     <= '0;
        has_aud <= start_aud;
        vcnt    <= start_vcnt;
        abank   <= start_abank;
        vbank   <= start_vbank;
      end
    end else if (fire) begin
      if (sec_end) begin
        st  <= nxt_after;
        pos <= '0;
      end else begin
        pos <= pos + 16'd1;
      end
    end
  end
endmodule

// File: rtl/avmux.sv
module avmux #(
  parameter int          AUD_BYTES = 4,
  parameter int          VID_MAX   = 8,
  parameter logic [15:0] SOF       = 16'hB5C3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aud_valid,
  input  logic [7:0] aud_data,
  output logic       aud_ready,
  input  logic       vid_valid,
  input  logic [7:0] vid_data,
  output logic       vid_ready,
  input  logic       aud_done,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int AAW = $clog2(AUD_BYTES);
  localparam int VAW = $clog2(VID_MAX);
  localparam int ACW = $clog2(AUD_BYTES + 1);
  localparam int VCW = $clog2(VID_MAX + 1);

  logic           pend_aud, req_aud, vid_full, tx_busy;
  logic           swap_now, swap_aud;
  logic [ACW-1:0] a_cnt;
  logic [VCW-1:0] v_cnt;
  logic           a_fill, v_fill, a_rsel, v_rsel;
  logic [AAW-1:0] a_addr;
  logic [VAW-1:0] v_addr;
  logic [7:0]     a_rdata, v_rdata;

  assign req_aud  = pend_aud || aud_done;
  assign vid_full = (v_cnt == VCW'(VID_MAX));
  assign swap_now = !tx_busy && (req_aud || vid_full);
  assign swap_aud = swap_now && req_aud;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_aud <= 1'b0;
    else        pend_aud <= req_aud && !swap_now;
  end

  avmux_bank #(.DEPTH(AUD_BYTES)) u_aud (
    .clk(clk), .rst_n(rst_n),
    .in_valid(aud_valid), .in_data(aud_data), .hold(req_aud), .in_ready(aud_ready),
    .swap(swap_aud), .fill_cnt(a_cnt), .fill_sel(a_fill),
    .rd_sel(a_rsel), .rd_addr(a_addr), .rd_data(a_rdata)
  );

  avmux_bank #(.DEPTH(VID_MAX)) u_vid (
    .clk(clk), .rst_n(rst_n),
    .in_valid(vid_valid), .in_data(vid_data), .hold(swap_now), .in_ready(vid_ready),
    .swap(swap_now), .fill_cnt(v_cnt), .fill_sel(v_fill),
    .rd_sel(v_rsel), .rd_addr(v_addr), .rd_data(v_rdata)
  );

  avmux_tx #(.AUD_BYTES(AUD_BYTES), .VID_MAX(VID_MAX), .SOF(SOF)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .start(swap_now), .start_aud(swap_aud), .start_vcnt(v_cnt),
    .start_abank(a_fill), .start_vbank(v_fill),
    .busy(tx_busy),
    .a_sel(a_rsel), .a_addr(a_addr), .a_data(a_rdata),
    .v_sel(v_rsel), .v_addr(v_addr), .v_data(v_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/avmux_chk.sv
module avmux_chk #(
  parameter int          AUD_BYTES = 4,
  parameter int          VID_MAX   = 8,
  parameter logic [15:0] SOF       = 16'hB5C3,
  localparam int ACW = $clog2(AUD_BYTES + 1),
  localparam int VCW = $clog2(VID_MAX + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           out_valid,
  input logic           out_ready,
  input logic [7:0]     out_data,
  input logic           out_last,
  input logic           swap_now,
  input logic [ACW-1:0] a_cnt,
  input logic [VCW-1:0] v_cnt
);
  // R7: offered byte held under back-pressure
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6: one idle cycle after every accepted last byte
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  // R6: a swap never happens while a frame is still leaving
  p_swap_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_now |-> !out_valid);

  // R2: first byte of every frame is the marker high byte
  p_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_data == SOF[15:8]);

  // R4: audio half never holds more than one chunk
  p_aud_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_cnt <= ACW'(AUD_BYTES));

  // R5: video half never overflows its limit
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    v_cnt <= VCW'(VID_MAX));
endmodule

bind avmux avmux_chk #(.AUD_BYTES(AUD_BYTES), .VID_MAX(VID_MAX), .SOF(SOF)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .swap_now(swap_now), .a_cnt(a_cnt), .v_cnt(v_cnt)
);

// File: tb/tb_avmux.sv
`timescale 1ns/1ps
module tb_avmux;
  localparam int          A    = 3;
  localparam int          V    = 4;
  localparam int          HB   = 5;
  localparam logic [15:0] MARK = 16'hC3A5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aud_valid, vid_valid, aud_done, out_ready;
  logic [7:0] aud_data, vid_data;
  logic       aud_ready, vid_ready, out_valid, out_last;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  avmux #(.AUD_BYTES(A), .VID_MAX(V), .SOF(MARK)) dut (
    .clk(clk), .rst_n(rst_n),
    .aud_valid(aud_valid), .aud_data(aud_data), .aud_ready(aud_ready),
    .vid_valid(vid_valid), .vid_data(vid_data), .vid_ready(vid_ready),
    .aud_done(aud_done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int         checks = 0;
  int         failures = 0;
  logic [7:0] exp_b [64];
  int         exp_n = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic mk_exp(input bit ha, input logic [7:0] as, input int nv, input logic [7:0] vs);
    int sz;
    int k;
    sz = HB + (ha ? A : 0) + nv;
    exp_b[0] = MARK[15:8];
    exp_b[1] = MARK[7:0];
    exp_b[2] = ha ? ((nv > 0) ? 8'd2 : 8'd0) : 8'd1;
    exp_b[3] = 8'(sz >> 8);
    exp_b[4] = 8'(sz);
    k = HB;
    if (ha) for (int i = 0; i < A; i++) begin exp_b[k] = as + 8'(i); k++; end
    for (int i = 0; i < nv; i++) begin exp_b[k] = vs + 8'(i); k++; end
    exp_n = k;
  endtask

  task automatic push_aud(input int n, input logic [7:0] seed);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      aud_valid = 1'b1; aud_data = seed + 8'(i); #1;
      while (!aud_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    aud_valid = 1'b0;
  endtask

  task automatic push_vid(input int n, input logic [7:0] seed);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      vid_valid = 1'b1; vid_data = seed + 8'(i); #1;
      while (!vid_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    vid_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    aud_done = 1'b1; #1;
    chk(!aud_ready, "R6", "aud_ready low at done", aud_ready, 0);
    @(negedge clk);
    aud_done = 1'b0;
  endtask

  task automatic collect(input int pat, input string body_tag);
    logic [7:0] got [64];
    int         n = 0;
    int         cyc = 0;
    bit         done = 1'b0;
    bit         stall = 1'b0;
    logic [7:0] sd = 8'h00;
    while (!done) begin
      @(negedge clk);
      out_ready = ((cyc % pat) == 0);
      cyc++;
      #1;
      if (stall) chk(out_valid === 1'b1 && out_data === sd, "R7", "byte held under back-pressure", out_data, sd);
      stall = out_valid && !out_ready;
      sd = out_data;
      if (out_valid && out_ready) begin
        if (n < 64) got[n] = out_data;
        n++;
        if (out_last) done = 1'b1;
      end
    end
    @(negedge clk);
    out_ready = 1'b0; #1;
    chk(!out_valid, "R6", "idle cycle after last byte", out_valid, 0);
    chk(n == exp_n, "R1", "frame length at out_last", n, exp_n);
    for (int i = 0; i < exp_n && i < n; i++)
      chk(got[i] == exp_b[i], (i == 2) ? "R3" : ((i < HB) ? "R2" : body_tag),
          $sformatf("byte %0d", i), got[i], exp_b[i]);
  endtask

  initial begin
    aud_valid = 1'b0; vid_valid = 1'b0; aud_done = 1'b0; out_ready = 1'b0;
    aud_data = 8'h00; vid_data = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R8", "out_valid in reset", out_valid, 0);
    chk(aud_ready, "R8", "aud_ready in reset", aud_ready, 1);
    chk(vid_ready, "R8", "vid_ready in reset", vid_ready, 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid, "R8", "out_valid after reset", out_valid, 0);

    // R4: every video count that fits beside an audio chunk
    for (int v = 0; v < V; v++) begin
      push_aud(A, 8'h10 + 8'(v * 16));
      push_vid(v, 8'h80 + 8'(v * 16));
      pulse_done();
      mk_exp(1'b1, 8'h10 + 8'(v * 16), v, 8'h80 + 8'(v * 16));
      collect(1 + v % 3, "R4");
    end

    // R5: full video half forces a video-only frame, audio stays for later
    push_aud(A, 8'h50);
    push_vid(V, 8'hC0);
    #1;
    chk(!vid_ready, "R5", "vid_ready low when full", vid_ready, 0);
    mk_exp(1'b0, 8'h00, V, 8'hC0);
    collect(2, "R5");
    chk(!aud_ready, "R5", "audio chunk kept after video swap", aud_ready, 0);
    pulse_done();
    mk_exp(1'b1, 8'h50, 0, 8'h00);
    collect(1, "R5");

    // R6 and R9: second swap requested while the first frame is leaving
    push_aud(A, 8'h21);
    push_vid(2, 8'h61);
    pulse_done();
    mk_exp(1'b1, 8'h21, 2, 8'h61);
    fork
      collect(3, "R6");
      begin
        push_aud(A, 8'h31);
        push_vid(V, 8'h71);
        #1;
        chk(out_valid, "R9", "sources filled while frame sending", out_valid, 1);
        chk(!vid_ready, "R5", "vid_ready low while swap deferred", vid_ready, 0);
        pulse_done();
        #1;
        chk(!aud_ready, "R6", "aud_ready low while swap waits", aud_ready, 0);
        chk(out_valid, "R6", "first frame still sending", out_valid, 1);
      end
    join
    mk_exp(1'b1, 8'h31, V, 8'h71);
    collect(2, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule